// File: doc/BRIEF.md
# Configurable UART Transmit Framer

This block turns bytes into asynchronous serial frames. Bytes are written into a small transmit queue. A serializer takes them one at a time and sends each as a frame. The serializer only advances on a bit-rate tick enable, which runs at eight ticks per serial bit. The frame shape comes from static control inputs: data length (7 or 8 bits), stop bit count (1 or 2), and a parity enable with a two-bit parity mode.

Software-side logic pushes bytes with a one-cycle write strobe and uses the free-space count to pace itself. A break input forces the serial line low. A loopback input sends the frame to an internal return line and holds the external pin idle. A flush input empties the queue without stopping a frame that is already on the line. Frame format inputs are read once, when a frame starts.

Top module: `uart_tx_framer`

## Requirements
- R1: After reset, `txd` and `lb_line` are high, `tx_active` is 0, `free_count` is 16 and `tx_overflow` is 0. Whenever no frame is in progress and break is off, both lines are high.
- R2: A frame begins with one low start bit, then sends data least significant bit first. Every bit lasts exactly 8 `tick` pulses, and a frame starts only on a `tick` cycle.
- R3: With `cfg_eight_bits` = 1, eight data bits are sent. With `cfg_eight_bits` = 0, only bits 6..0 are sent and bit 7 of the byte is ignored.
- R4: With `cfg_two_stop` = 0, one high stop bit ends the frame. With `cfg_two_stop` = 1, two high stop bits end it.
- R5: With `cfg_parity_en` = 1, one parity bit follows the data. The value of `cfg_parity_mode` selects it: 0 makes the count of ones over the sent data bits plus parity odd, 1 makes that count even, 2 sends a constant 0, and 3 sends a constant 1. In 7-bit mode only the 7 sent bits count.
- R6: The queue holds 16 bytes. `free_count` (5 bits) equals 16 minus the number of queued bytes, and it updates in the cycle after a write.
- R7: A write while the queue is full is dropped and sets `tx_overflow`. That flag stays set until `fifo_flush`.
- R8: `fifo_flush` empties the queue, so no discarded byte is ever sent.
- R9: While `cfg_break` is 1, `txd` is low, with no added delay.
- R10: With `cfg_loopback` = 1, the frame appears on `lb_line` and `txd` stays high. With it at 0, `lb_line` stays high.
- R11: While `cfg_enable` is 0, no frame starts and queued bytes stay in the queue.
- R12: `tx_active` is 1 from the start bit through the end of the last stop bit, and 0 afterwards when nothing else is queued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | Oversampling enable, 8 per serial bit |
| cfg_enable | input | 1 | Allows new frames to start |
| cfg_eight_bits | input | 1 | 1: 8 data bits, 0: 7 data bits |
| cfg_two_stop | input | 1 | 1: two stop bits |
| cfg_parity_en | input | 1 | Adds a parity bit |
| cfg_parity_mode | input | 2 | 0 odd, 1 even, 2 space, 3 mark |
| cfg_break | input | 1 | Forces the serial line low |
| cfg_loopback | input | 1 | Routes the frame to `lb_line` |
| fifo_flush | input | 1 | Discards all queued bytes, clears overflow |
| wr_valid | input | 1 | Write strobe for `wr_data` |
| wr_data | input | 8 | Byte to queue |
| txd | output | 1 | External serial line |
| lb_line | output | 1 | Internal loopback line |
| tx_active | output | 1 | Frame in progress |
| free_count | output | 5 | Free queue entries |
| tx_overflow | output | 1 | Sticky dropped-write flag |

## Verification
The assertions assume the following about the inputs:
- The format inputs do not change while a frame is on the line, since the expected frame is built from the values at frame start.
- `tick` is a single-cycle pulse, never high in two consecutive cycles.

The stimulus respects both assumptions. It changes format only while `tx_active` is low. It pulses `tick` once every three clocks from a divider that is separate from the design. Break and loopback are changed only while the line is idle, so each frame is sampled in the middle of every bit without interference.

// File: rtl/uart_txf_pkg.sv
package uart_txf_pkg;

    localparam int unsigned BYTE_W    = 8;
    localparam int unsigned FRAME_MAX = 12;  // start + 8 data + parity + 2 stop
    localparam int unsigned LEN_W     = $clog2(FRAME_MAX + 1);

    typedef enum logic [1:0] {
        PAR_ODD   = 2'd0,
        PAR_EVEN  = 2'd1,
        PAR_SPACE = 2'd2,
        PAR_MARK  = 2'd3
    } par_mode_e;

    typedef struct packed {
        logic      eight_bits;
        logic      two_stop;
        logic      par_en;
        par_mode_e par_mode;
    } frame_cfg_t;

    // Parity over the data bits that are actually transmitted.
    function automatic logic parity_bit(input logic [BYTE_W-1:0] d,
                                        input frame_cfg_t cfg);
        logic ones;
        ones = cfg.eight_bits ? ^d : ^d[BYTE_W-2:0];
        case (cfg.par_mode)
            PAR_ODD:   return ~ones;
            PAR_EVEN:  return ones;
            PAR_SPACE: return 1'b0;
            default:   return 1'b1;
        endcase
    endfunction

    // Total bit count of one frame, start bit included.
    function automatic logic [LEN_W-1:0] frame_len(input frame_cfg_t cfg);
        int unsigned n;
        n = 1 + (cfg.eight_bits ? 8 : 7) + (cfg.par_en ? 1 : 0) + (cfg.two_stop ? 2 : 1);
        return LEN_W'(n);
    endfunction

endpackage

// File: rtl/txf_fifo.sv
module txf_fifo #(
    parameter int unsigned DEPTH = 16,
    parameter int unsigned WIDTH = 8,
    localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             flush,
    input  logic             push,
    input  logic [WIDTH-1:0] push_data,
    input  logic             pop,
    output logic [WIDTH-1:0] head_data,
    output logic             empty,
    output logic [CNT_W-1:0] free_cnt,
    output logic             overflow
);

    logic [WIDTH-1:0] mem [DEPTH];
    logic [PTR_W-1:0] wr_ptr, rd_ptr;
    logic [CNT_W-1:0] count;
    logic             full, do_push, do_pop;

    localparam logic [CNT_W-1:0] DEPTH_C = CNT_W'(DEPTH);
    localparam logic [PTR_W-1:0] LAST_P  = PTR_W'(DEPTH - 1);

    assign full      = (count == DEPTH_C);
    assign empty     = (count == '0);
    assign do_push   = push && !full && !flush;
    assign do_pop    = pop && !empty && !flush;
    assign head_data = mem[rd_ptr];
    assign free_cnt  = DEPTH_C - count;

    always_ff @(posedge clk) begin
        if (do_push) mem[wr_ptr] <= push_data;
    end

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (do_push) wr_ptr <= (wr_ptr == LAST_P) ? '0 : wr_ptr + 1'b1;
            if (do_pop)  rd_ptr <= (rd_ptr == LAST_P) ? '0 : rd_ptr + 1'b1;
            count <= count + CNT_W'(do_push) - CNT_W'(do_pop);
        end
    end

    always_ff @(posedge clk) begin
        if (rst || flush)           overflow <= 1'b0;
        else if (push && full)      overflow <= 1'b1;
    end

    AST_COUNT_BOUND: assert property (@(posedge clk) disable iff (rst)
        count <= DEPTH_C);                                              // R6
    AST_FULL_DROP: assert property (@(posedge clk) disable iff (rst)
        (full && push && !pop && !flush) |=> (count == DEPTH_C && overflow)); // R7
    AST_OVF_STICKY: assert property (@(posedge clk) disable iff (rst)
        (overflow && !flush) |=> overflow);                              // R7
    AST_FLUSH_EMPTY: assert property (@(posedge clk) disable iff (rst)
        flush |=> (empty && !overflow));                                 // R8

endmodule

// File: rtl/txf_serializer.sv
module txf_serializer
    import uart_txf_pkg::*;
#(
    parameter int unsigned OVERSAMPLE = 8,
    localparam int unsigned TC_W = (OVERSAMPLE > 1) ? $clog2(OVERSAMPLE) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tick,
    input  logic              enable,
    input  frame_cfg_t        cfg,
    input  logic              have_data,
    input  logic [BYTE_W-1:0] data,
    output logic              pop,
    output logic              line,
    output logic              busy
);

    localparam logic [TC_W-1:0] TC_LAST = TC_W'(OVERSAMPLE - 1);

    logic [FRAME_MAX-1:0] shreg, frame;
    logic [LEN_W-1:0]     bits_left;
    logic [TC_W-1:0]      tcnt;
    logic [BYTE_W:0]      data_x;
    logic                 par;
    int unsigned          nd;

    // Frame image, LSB goes out first; unused upper bits are idle-high.
    always_comb begin
        data_x = {1'b0, data};
        par    = parity_bit(data, cfg);
        nd     = cfg.eight_bits ? 8 : 7;
        frame  = '1;
        frame[0] = 1'b0;
        for (int i = 0; i < 9; i++) begin
            if (i < nd)                      frame[i+1] = data_x[i];
            else if (i == nd && cfg.par_en)  frame[i+1] = par;
        end
    end

    assign pop  = tick && enable && !busy && have_data;
    assign line = busy ? shreg[0] : 1'b1;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy      <= 1'b0;
            shreg     <= '1;
            bits_left <= '0;
            tcnt      <= '0;
        end else if (pop) begin
            busy      <= 1'b1;
            shreg     <= frame;
            bits_left <= frame_len(cfg);
            tcnt      <= '0;
        end else if (busy && tick) begin
            if (tcnt == TC_LAST) begin
                tcnt      <= '0;
                shreg     <= {1'b1, shreg[FRAME_MAX-1:1]};
                bits_left <= bits_left - 1'b1;
                if (bits_left == LEN_W'(1)) busy <= 1'b0;
            end else begin
                tcnt <= tcnt + 1'b1;
            end
        end
    end

    AST_BIT_HOLD: assert property (@(posedge clk) disable iff (rst)
        (busy && !tick) |=> $stable(line));                 // R2
    AST_START_LOW: assert property (@(posedge clk) disable iff (rst)
        pop |=> (busy && !line));                           // R2
    AST_NO_START_OFF: assert property (@(posedge clk) disable iff (rst)
        (!busy && !enable) |=> !busy);                      // R11

endmodule

// File: rtl/uart_tx_framer.sv
module uart_tx_framer
    import uart_txf_pkg::*;
#(
    parameter int unsigned FIFO_DEPTH = 16,
    parameter int unsigned OVERSAMPLE = 8,
    localparam int unsigned CNT_W = $clog2(FIFO_DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick,
    input  logic             cfg_enable,
    input  logic             cfg_eight_bits,
    input  logic             cfg_two_stop,
    input  logic             cfg_parity_en,
    input  logic [1:0]       cfg_parity_mode,
    input  logic             cfg_break,
    input  logic             cfg_loopback,
    input  logic             fifo_flush,
    input  logic             wr_valid,
    input  logic [7:0]       wr_data,
    output logic             txd,
    output logic             lb_line,
    output logic             tx_active,
    output logic [CNT_W-1:0] free_count,
    output logic             tx_overflow
);

    frame_cfg_t        cfg;
    logic [BYTE_W-1:0] head;
    logic              empty, pop, ser_line, wire_line;

    assign cfg = '{eight_bits: cfg_eight_bits,
                   two_stop:   cfg_two_stop,
                   par_en:     cfg_parity_en,
                   par_mode:   par_mode_e'(cfg_parity_mode)};

    txf_fifo #(.DEPTH(FIFO_DEPTH), .WIDTH(BYTE_W)) u_fifo (
        .clk       (clk),
        .rst       (rst),
        .flush     (fifo_flush),
        .push      (wr_valid),
        .push_data (wr_data),
        .pop       (pop),
        .head_data (head),
        .empty     (empty),
        .free_cnt  (free_count),
        .overflow  (tx_overflow)
    );

    txf_serializer #(.OVERSAMPLE(OVERSAMPLE)) u_ser (
        .clk       (clk),
        .rst       (rst),
        .tick      (tick),
        .enable    (cfg_enable),
        .cfg       (cfg),
        .have_data (!empty),
        .data      (head),
        .pop       (pop),
        .line      (ser_line),
        .busy      (tx_active)
    );

    assign wire_line = cfg_break ? 1'b0 : ser_line;
    assign txd       = cfg_loopback ? 1'b1 : wire_line;
    assign lb_line   = cfg_loopback ? wire_line : 1'b1;

    AST_IDLE_HIGH: assert property (@(posedge clk) disable iff (rst)
        (!cfg_break && !tx_active) |-> (txd && lb_line));          // R1
    AST_BREAK_LOW: assert property (@(posedge clk) disable iff (rst)
        (cfg_break && !cfg_loopback) |-> !txd);                    // R9
    AST_LOOP_PIN_IDLE: assert property (@(posedge clk) disable iff (rst)
        cfg_loopback |-> txd);                                     // R10

endmodule

// File: tb/tb_uart_tx_framer.sv
`timescale 1ns/1ps
module tb_uart_tx_framer;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       tick;
    logic       cfg_enable = 0, cfg_eight_bits = 1, cfg_two_stop = 0;
    logic       cfg_parity_en = 0, cfg_break = 0, cfg_loopback = 0;
    logic [1:0] cfg_parity_mode = 2'd0;
    logic       fifo_flush = 0, wr_valid = 0;
    logic [7:0] wr_data = 8'h00;
    logic       txd, lb_line, tx_active, tx_overflow;
    logic [4:0] free_count;

    int n_checks = 0;
    int n_err    = 0;
    bit done     = 0;
    int div      = 0;

    always #2 clk = ~clk;

    always @(negedge clk) begin
        if (rst) div <= 0;
        else     div <= (div == 2) ? 0 : div + 1;
    end
    assign tick = !rst && (div == 0);

    uart_tx_framer dut (
        .clk(clk), .rst(rst), .tick(tick),
        .cfg_enable(cfg_enable), .cfg_eight_bits(cfg_eight_bits),
        .cfg_two_stop(cfg_two_stop), .cfg_parity_en(cfg_parity_en),
        .cfg_parity_mode(cfg_parity_mode), .cfg_break(cfg_break),
        .cfg_loopback(cfg_loopback), .fifo_flush(fifo_flush),
        .wr_valid(wr_valid), .wr_data(wr_data),
        .txd(txd), .lb_line(lb_line), .tx_active(tx_active),
        .free_count(free_count), .tx_overflow(tx_overflow)
    );

    task automatic check(input bit ok, input string req,
                         input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wait_ticks(input int n);
        repeat (n) begin
            @(posedge clk);
            while (!tick) @(posedge clk);
        end
    endtask

    task automatic write_byte(input logic [7:0] d);
        @(negedge clk);
        wr_valid = 1'b1;
        wr_data  = d;
        @(negedge clk);
        wr_valid = 1'b0;
    endtask

    task automatic do_flush();
        @(negedge clk);
        fifo_flush = 1'b1;
        @(negedge clk);
        fifo_flush = 1'b0;
    endtask

    function automatic logic [11:0] model(input logic [7:0] d, input bit eight,
                                          input bit two, input bit pen,
                                          input logic [1:0] pm, output int n);
        logic [11:0] b;
        int k, nd;
        logic ones, p;
        b = '1; k = 0; ones = 0;
        b[k] = 1'b0; k++;
        nd = eight ? 8 : 7;
        for (int i = 0; i < nd; i++) begin
            b[k] = d[i]; ones ^= d[i]; k++;
        end
        if (pen) begin
            p = (pm == 2'd0) ? ~ones : (pm == 2'd1) ? ones : (pm == 2'd2) ? 1'b0 : 1'b1;
            b[k] = p; k++;
        end
        n = k + (two ? 2 : 1);
        return b;
    endfunction

    // Sends one byte with the current format, samples mid-bit and compares.
    task automatic send_and_check(input logic [7:0] d, input bit use_lb, input string req);
        logic [11:0] exp, got;
        int n, guard;
        bit other_ok, act_ok;
        exp = model(d, cfg_eight_bits, cfg_two_stop, cfg_parity_en, cfg_parity_mode, n);
        got = '1; other_ok = 1; act_ok = 1; guard = 0;
        cfg_enable = 1'b1;
        write_byte(d);
        while ((use_lb ? lb_line : txd) !== 1'b0 && guard < 3000) begin
            @(negedge clk); guard++;
        end
        check(guard < 3000, {req, " start bit seen"}, guard, 0);
        if (guard >= 3000) return;
        wait_ticks(4);
        @(negedge clk);
        for (int b = 0; b < n; b++) begin
            if (b > 0) begin wait_ticks(8); @(negedge clk); end
            got[b] = use_lb ? lb_line : txd;
            if (use_lb && txd !== 1'b1) other_ok = 0;
            if (!use_lb && lb_line !== 1'b1) other_ok = 0;
            if (tx_active !== 1'b1) act_ok = 0;
        end
        check(got == exp, req, got, exp);
        check(other_ok, {req, " R10 other line idle"}, other_ok, 1);
        check(act_ok, {req, " R12 active during frame"}, act_ok, 1);
        wait_ticks(5);
        @(negedge clk);
        check(tx_active == 1'b0, {req, " R12 active clears"}, tx_active, 0);
        check(txd == 1'b1 && lb_line == 1'b1, {req, " R1 idle high after frame"},
              {txd, lb_line}, 2'b11);
        cfg_enable = 1'b0;
    endtask

    task automatic t_reset();
        check(txd == 1 && lb_line == 1, "R1 lines high at reset", {txd, lb_line}, 2'b11);
        check(tx_active == 0, "R1 active low at reset", tx_active, 0);
        check(free_count == 5'd16, "R1 free 16 at reset", free_count, 16);
        check(tx_overflow == 0, "R1 overflow clear at reset", tx_overflow, 0);
    endtask

    task automatic t_basic_8n1();
        cfg_eight_bits = 1; cfg_two_stop = 0; cfg_parity_en = 0;
        send_and_check(8'hA5, 0, "R2 8N1 A5");
        send_and_check(8'h01, 0, "R2 8N1 01");
    endtask

    task automatic t_seven_bit();
        cfg_eight_bits = 0; cfg_two_stop = 0; cfg_parity_en = 0;
        send_and_check(8'hC3, 0, "R3 7N1 bit7 ignored");
        cfg_eight_bits = 1;
    endtask

    task automatic t_two_stop();
        cfg_two_stop = 1;
        send_and_check(8'h5A, 0, "R4 8N2");
        cfg_two_stop = 0;
    endtask

    task automatic t_parity();
        cfg_parity_en = 1;
        for (int m = 0; m < 4; m++) begin
            cfg_parity_mode = 2'(m);
            send_and_check(8'h07, 0, $sformatf("R5 parity mode %0d", m));
        end
        cfg_eight_bits = 0; cfg_parity_mode = 2'd0;
        send_and_check(8'h81, 0, "R5 odd parity over 7 bits");
        cfg_parity_mode = 2'd1;
        send_and_check(8'hFE, 0, "R5 even parity over 7 bits");
        cfg_eight_bits = 1; cfg_parity_en = 0;
    endtask

    task automatic t_disabled();
        int lows = 0;
        cfg_enable = 0;
        write_byte(8'h00); write_byte(8'h00); write_byte(8'h00);
        for (int i = 0; i < 150; i++) begin
            @(negedge clk);
            if (txd !== 1'b1 || tx_active !== 1'b0) lows++;
        end
        check(lows == 0, "R11 no frame while disabled", lows, 0);
        check(free_count == 5'd13, "R11 queued bytes kept", free_count, 13);
        do_flush();
    endtask

    task automatic t_fill_overflow();
        cfg_enable = 0;
        for (int i = 0; i < 16; i++) write_byte(8'(i));
        check(free_count == 5'd0, "R6 free 0 when full", free_count, 0);
        check(tx_overflow == 0, "R7 no overflow at exactly full", tx_overflow, 0);
        write_byte(8'hEE);
        check(free_count == 5'd0, "R7 write to full dropped", free_count, 0);
        check(tx_overflow == 1, "R7 overflow set", tx_overflow, 1);
        repeat (5) @(negedge clk);
        check(tx_overflow == 1, "R7 overflow sticky", tx_overflow, 1);
        do_flush();
        check(free_count == 5'd16, "R8 flush empties", free_count, 16);
        check(tx_overflow == 0, "R7 flush clears overflow", tx_overflow, 0);
    endtask

    task automatic t_flush_discard();
        int lows = 0;
        cfg_enable = 0;
        write_byte(8'h00); write_byte(8'h00);
        check(free_count == 5'd14, "R6 free after two writes", free_count, 14);
        do_flush();
        cfg_enable = 1;
        for (int i = 0; i < 200; i++) begin
            @(negedge clk);
            if (txd !== 1'b1) lows++;
        end
        check(lows == 0, "R8 flushed bytes never sent", lows, 0);
        cfg_enable = 0;
    endtask

    task automatic t_break();
        @(negedge clk);
        cfg_break = 1;
        #1;
        check(txd == 1'b0, "R9 break drives low", txd, 0);
        repeat (10) @(negedge clk);
        check(txd == 1'b0, "R9 break held low", txd, 0);
        cfg_break = 0;
        #1;
        check(txd == 1'b1, "R9 release returns high", txd, 1);
    endtask

    task automatic t_loopback();
        @(negedge clk);
        cfg_loopback = 1;
        send_and_check(8'h3C, 1, "R10 loopback frame");
        cfg_loopback = 0;
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_basic_8n1();
        t_seven_bit();
        t_two_stop();
        t_parity();
        t_disabled();
        t_fill_overflow();
        t_flush_discard();
        t_break();
        t_loopback();
        done = 1;
        $display("Result: errors=%0d of %0d checks", n_err, n_checks);
        $finish;
    end

    initial begin
        #(200000 * 4);
        if (!done) begin
            n_checks++;
            n_err++;
            $display("FAIL watchdog R12 actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", n_err, n_checks);
            $finish;
        end
    end

endmodule